// File: doc/BRIEF.md
# Issue Width Power Controller

This block picks, every cycle, between a full-width issue mode (eight instructions per cycle, both integer ALU clusters active) and a low-power mode (four per cycle, the auxiliary integer cluster switched off). Control comes from two sources. Compile-time profiling tags the start of some code blocks with a 2-bit hint, and the decoder passes that hint along with a block-start strobe. A hardware monitor sums the integer instructions retired over fixed 256-cycle windows and compares the total against a programmable threshold.

A block that carries a hint is steered by the hint alone, and the change takes effect one cycle after the strobe. A block without a hint leaves the decision to the monitor. The monitor judges the mode only at window boundaries. The threshold is given in instructions per window, so no division is needed. The cluster enable is held high while the cluster still has operations in flight. The narrowed issue width already keeps new work away from that cluster.

Top module: `issue_width_ctrl`

## Requirements
- R1: After reset the issue width output reads 8 and the cluster enable reads 1.
- R2: The monitor window is 256 cycles long, starting on the first clock edge after reset. The decision uses the sum of the retire counts of all 256 cycles, and mode changes only one cycle after the window's last cycle, never earlier.
- R3: With no hint in force, a window sum below the threshold sets the width to 4 on the cycle after the window ends.
- R4: With no hint in force, a window sum at or above the threshold sets the width to 8 on the cycle after the window ends. Low-power mode is never left mid-window.
- R5: A block-start strobe with hint 01 sets the width to 4 on the next cycle, whatever the window state.
- R6: A block-start strobe with hint 10 sets the width to 8 on the next cycle.
- R7: While the current block carries hint 01 or 10, window results do not change the mode.
- R8: Hint 00 and hint 11 both mean "no hint". A strobe carrying either one leaves the mode unchanged and returns control to the monitor. Apart from a strobe or a window end, the width never changes.
- R9: When low-power mode is in force, the cluster enable stays 1 while the busy flag is 1. It falls on the first edge at which the busy flag is 0.
- R10: When a strobe falls on a window's last cycle, a hinted strobe decides the mode. An unhinted strobe lets that window's result decide.
- R11: Whenever the width reads 8, the cluster enable reads 1. Both return together on leaving low-power mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| retire_cnt_i | input | 4 | Integer instructions retired this cycle (0 to 8) |
| blk_start_i | input | 1 | Decoded block-start strobe |
| blk_hint_i | input | 2 | Block hint: 00 none, 01 low power, 10 full width, 11 none |
| thresh_i | input | 12 | Threshold in retired instructions per 256-cycle window |
| clus_busy_i | input | 1 | Auxiliary integer cluster still has operations in flight |
| issue_width_o | output | 4 | Issue width, 8 or 4 |
| clus_en_o | output | 1 | Auxiliary integer cluster enable |

## Verification
The monitor's window decision and a decoded block strobe can land on the same clock edge. The bench provokes this by raising the strobe exactly on the 256th cycle of a window. It does so three times: with hint 01 while the sum is above threshold, with hint 10 while the sum is zero, and with hint 00 while the sum is zero. The mode one cycle later shows whether the hint won or whether the window was allowed to decide. The cluster-enable handshake is checked in a separate window, in which the busy flag is held high across a hint-driven entry into low-power mode.

// File: rtl/iwc_pkg.sv
package iwc_pkg;
  typedef enum logic [1:0] {
    HINT_NONE = 2'b00,
    HINT_LOW  = 2'b01,
    HINT_FULL = 2'b10,
    HINT_RSVD = 2'b11
  } hint_e;

  // reserved code behaves as "no hint"
  function automatic hint_e hint_decode(input logic [1:0] raw);
    hint_e h;
    h = hint_e'(raw);
    if (h == HINT_RSVD) h = HINT_NONE;
    return h;
  endfunction
endpackage

// File: rtl/iwc_window_mon.sv
module iwc_window_mon #(
  parameter int unsigned WIN_CYCLES = 256,
  parameter int unsigned RET_W      = 4,
  parameter int unsigned ACC_W      = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RET_W-1:0] retire_cnt_i,
  input  logic [ACC_W-1:0] thresh_i,
  output logic             win_end_o,
  output logic             win_low_o
);
  localparam int unsigned WIN_W = $clog2(WIN_CYCLES);

  logic [WIN_W-1:0] win_q;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;

  assign win_end_o = (win_q == WIN_W'(WIN_CYCLES - 1));
  assign sum       = acc_q + ACC_W'(retire_cnt_i);
  assign win_low_o = (sum < thresh_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      acc_q <= '0;
    end else if (win_end_o) begin
      win_q <= '0;
      acc_q <= '0;
    end else begin
      win_q <= win_q + 1'b1;
      acc_q <= sum;
    end
  end
endmodule

// File: rtl/iwc_mode_fsm.sv
module iwc_mode_fsm
  import iwc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       blk_start_i,
  input  logic [1:0] blk_hint_i,
  input  logic       win_end_i,
  input  logic       win_low_i,
  output logic       low_d_o,
  output logic       low_q_o
);
  hint_e cur_q, eff;

  assign eff = blk_start_i ? hint_decode(blk_hint_i) : cur_q;

  always_comb begin
    low_d_o = low_q_o;
    unique case (eff)
      HINT_LOW:  low_d_o = 1'b1;
      HINT_FULL: low_d_o = 1'b0;
      default:   if (win_end_i) low_d_o = win_low_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q   <= HINT_NONE;
      low_q_o <= 1'b0;
    end else begin
      cur_q   <= eff;
      low_q_o <= low_d_o;
    end
  end
endmodule

// File: rtl/iwc_clus_gate.sv
module iwc_clus_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic low_d_i,
  input  logic busy_i,
  output logic clus_en_o
);
  // once dropped in low mode it stays off until full width returns
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clus_en_o <= 1'b1;
    else         clus_en_o <= !low_d_i || (clus_en_o && busy_i);
  end
endmodule

// File: rtl/issue_width_ctrl.sv
module issue_width_ctrl #(
  parameter int unsigned WIN_CYCLES  = 256,
  parameter int unsigned MAX_RETIRE  = 8,
  parameter int unsigned FULL_WIDTH  = 8,
  parameter int unsigned LOW_WIDTH   = 4,
  localparam int unsigned RET_W = $clog2(MAX_RETIRE + 1),
  localparam int unsigned ACC_W = $clog2(WIN_CYCLES * MAX_RETIRE + 1),
  localparam int unsigned WID_W = $clog2(FULL_WIDTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RET_W-1:0] retire_cnt_i,
  input  logic             blk_start_i,
  input  logic [1:0]       blk_hint_i,
  input  logic [ACC_W-1:0] thresh_i,
  input  logic             clus_busy_i,
  output logic [WID_W-1:0] issue_width_o,
  output logic             clus_en_o
);
  logic win_end, win_low, low_d, low_q;

  iwc_window_mon #(.WIN_CYCLES(WIN_CYCLES), .RET_W(RET_W), .ACC_W(ACC_W)) u_win (
    .clk_i, .rst_ni, .retire_cnt_i, .thresh_i,
    .win_end_o(win_end), .win_low_o(win_low)
  );

  iwc_mode_fsm u_mode (
    .clk_i, .rst_ni, .blk_start_i, .blk_hint_i,
    .win_end_i(win_end), .win_low_i(win_low),
    .low_d_o(low_d), .low_q_o(low_q)
  );

  iwc_clus_gate u_gate (
    .clk_i, .rst_ni, .low_d_i(low_d), .busy_i(clus_busy_i), .clus_en_o
  );

  assign issue_width_o = low_q ? WID_W'(LOW_WIDTH) : WID_W'(FULL_WIDTH);
endmodule

// File: rtl/iwc_checker.sv
module iwc_checker #(
  parameter int unsigned WID_W = 4,
  parameter int unsigned FULL_WIDTH = 8,
  parameter int unsigned LOW_WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             blk_start_i,
  input logic [1:0]       blk_hint_i,
  input logic             clus_busy_i,
  input logic             win_end,
  input logic [WID_W-1:0] issue_width_o,
  input logic             clus_en_o
);
  p_width_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_width_o == WID_W'(FULL_WIDTH)) || (issue_width_o == WID_W'(LOW_WIDTH)));

  p_hint_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_start_i && blk_hint_i == 2'b01) |=> (issue_width_o == WID_W'(LOW_WIDTH)));

  p_hint_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_start_i && blk_hint_i == 2'b10) |=> (issue_width_o == WID_W'(FULL_WIDTH)));

  p_quiet_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!blk_start_i && !win_end) |=> $stable(issue_width_o));

  p_busy_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clus_en_o && clus_busy_i) |=> clus_en_o);

  p_wide_enabled_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_width_o == WID_W'(FULL_WIDTH)) |-> clus_en_o);
endmodule

bind issue_width_ctrl iwc_checker #(
  .WID_W(WID_W), .FULL_WIDTH(FULL_WIDTH), .LOW_WIDTH(LOW_WIDTH)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .blk_start_i(blk_start_i), .blk_hint_i(blk_hint_i),
  .clus_busy_i(clus_busy_i), .win_end(win_end), .issue_width_o(issue_width_o),
  .clus_en_o(clus_en_o)
);

// File: tb/issue_width_ctrl_tb_top.sv
module issue_width_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  retire_cnt_i = '0;
  logic        blk_start_i = 1'b0;
  logic [1:0]  blk_hint_i = '0;
  logic [11:0] thresh_i = 12'd512;
  logic        clus_busy_i = 1'b0;
  logic [3:0]  issue_width_o;
  logic        clus_en_o;

  int n_run = 0, n_fail = 0, n_edge = 0;
  bit done = 0;

  typedef struct { int cyc; int width; bit en; string tag; } exp_t;
  exp_t q[$];

  always #2.5 clk_i = ~clk_i;

  issue_width_ctrl dut_i (.*);

  always @(posedge clk_i) if (rst_ni) n_edge <= n_edge + 1;

  function automatic void check(int w, bit e, string tag);
    n_run++;
    if (int'(issue_width_o) != w || clus_en_o != e) begin
      n_fail++;
      $display("FAIL %s: width=%0d en=%0b expected width=%0d en=%0b", tag,
               issue_width_o, clus_en_o, w, e);
    end
  endfunction

  task automatic expect_at(int cyc, int w, bit e, string tag);
    exp_t x;
    x.cyc = cyc; x.width = w; x.en = e; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic step(int ret, bit st, logic [1:0] h, bit busy);
    retire_cnt_i = 4'(ret); blk_start_i = st; blk_hint_i = h; clus_busy_i = busy;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  // monitor
  always @(negedge clk_i) begin
    while (q.size() > 0 && q[0].cyc <= n_edge) begin
      if (q[0].cyc < n_edge) begin
        n_run++; n_fail++;
        $display("FAIL %s: missed sample at %0d expected width=%0d", q[0].tag, q[0].cyc, q[0].width);
      end else check(q[0].width, q[0].en, q[0].tag);
      void'(q.pop_front());
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(8, 1'b1, "R1 reset");
    rst_ni = 1'b1;
    // W1: sum 256 < 512
    expect_at(255, 8, 1, "R2 no early change");
    expect_at(256, 4, 0, "R3 low after window");
    for (int i = 0; i < 256; i++) step(1, 0, 2'b00, 0);
    // W2: sum 512 == threshold
    expect_at(300, 4, 0, "R4 no mid-window exit");
    expect_at(512, 8, 1, "R4 R11 exit at boundary");
    for (int i = 0; i < 256; i++) step(2, 0, 2'b00, 0);
    // W3: low hint while busy
    expect_at(523, 4, 1, "R5 R9 hint low busy holds");
    expect_at(532, 4, 1, "R9 still busy");
    expect_at(533, 4, 0, "R9 drop after idle");
    expect_at(768, 4, 0, "R7 window ignored in low block");
    for (int i = 0; i < 256; i++) step(3, i == 10, 2'b01, i < 20);
    // W4: full hint, zero retire
    expect_at(769, 8, 1, "R6 hint full");
    expect_at(1024, 8, 1, "R7 window ignored in full block");
    for (int i = 0; i < 256; i++) step(0, i == 0, 2'b10, 0);
    // W5: reserved hint = none
    expect_at(1030, 8, 1, "R8 hint 11 no change");
    expect_at(1280, 4, 0, "R8 hint 11 monitor decides");
    for (int i = 0; i < 256; i++) step(0, i == 5, 2'b11, 0);
    // W6: hint 00
    expect_at(1286, 4, 0, "R8 hint 00 no change");
    expect_at(1536, 8, 1, "R8 hint 00 monitor exit");
    for (int i = 0; i < 256; i++) step(4, i == 5, 2'b00, 0);
    // W7: low hint on last cycle, sum high
    expect_at(1791, 8, 1, "R10 before coincidence");
    expect_at(1792, 4, 0, "R10 low hint wins");
    for (int i = 0; i < 256; i++) step(4, i == 255, 2'b01, 0);
    // W8: full hint on last cycle, sum zero
    expect_at(2047, 4, 0, "R10 before coincidence");
    expect_at(2048, 8, 1, "R10 full hint wins");
    for (int i = 0; i < 256; i++) step(0, i == 255, 2'b10, 0);
    // W9: unhinted start on last cycle, sum zero
    expect_at(2303, 8, 1, "R10 before coincidence");
    expect_at(2304, 4, 0, "R10 unhinted start lets window decide");
    for (int i = 0; i < 256; i++) step(0, i == 255, 2'b00, 0);
    step(0, 0, 2'b00, 0);
    if (q.size() != 0) begin
      n_run++; n_fail++;
      $display("FAIL R2: %0d expectations unchecked, expected 0", q.size());
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_run++; n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule